// File: doc/BRIEF.md
# Condition Flag and Predication Unit

This block holds the processor's four arithmetic condition flags (negative, zero, carry, overflow) together with a sticky saturation flag. Each cycle it looks at the 4-bit condition code of the instruction being presented and compares it with the flags currently held. It then raises an execute-enable that either lets the instruction commit or turns it into a no-op. The enable is combinational from the registered flags. Flag changes caused by the instruction take effect at the next rising clock edge.

An executed instruction that carries the set-flags qualifier loads new flag values from the ALU result and from the ALU's carry and overflow outputs. Logical operations take carry from the shifter and keep overflow. Add and subtract take carry and overflow from the adder, and on a subtract carry means "no borrow".

The saturation flag is set by hardware when an executed instruction reports saturation. Only a direct flag write clears it. The direct write port loads all five flags at once and takes priority over any update from an instruction in the same cycle.

Top module: `flag_pred_unit`

## Requirements
- R1: After reset all five flags read 0. flags_out packs the flags as bit 4 = N, bit 3 = Z, bit 2 = C, bit 1 = V, bit 0 = Q.
- R2: While instr_valid is 1, exec_en follows the condition code. Each code and its inverse:
  - 0000 passes when Z is set; 0001 when Z is clear.
  - 0010 passes when C is set; 0011 when C is clear.
  - 0100 passes when N is set; 0101 when N is clear.
  - 0110 passes when V is set; 0111 when V is clear.
  - 1000 passes when C is set and Z is clear; 1001 is its inverse.
  - 1010 passes when N equals V; 1011 is its inverse.
  - 1100 passes when Z is clear and N equals V; 1101 is its inverse.
  While instr_valid is 0, exec_en is 0.
- R3: Code 1110 always executes. Code 1111 never executes.
- R4: An executed flag-setting instruction sets N to the result's top bit. It sets Z to 1 exactly when the result is all zeros, and this includes a subtract whose difference is zero.
- R5: An executed flag-setting instruction with op_arith = 1 (add or subtract) loads C from adder_carry and V from adder_ovf.
- R6: An executed flag-setting instruction with op_arith = 0 (logical) loads C from shifter_carry and leaves V unchanged.
- R7: An executed instruction without set_flags leaves N, Z, C and V unchanged.
- R8: An instruction whose condition fails changes no flag, including Q, even when set_flags or sat_hit is 1.
- R9: An executed instruction with sat_hit = 1 sets Q. Once set, Q stays 1 through any instruction, flag-setting or not, until a direct write.
- R10: When wr_en is 1, all five flags take wr_flags (same bit order as R1) at the next edge. This overrides any instruction update in that cycle, and it is the only way to clear Q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| cond_code | input | 4 | Condition field of the instruction |
| set_flags | input | 1 | Instruction carries the set-flags qualifier |
| op_arith | input | 1 | 1 = add/subtract, 0 = logical |
| alu_result | input | DATA_W | ALU result |
| adder_carry | input | 1 | Adder carry-out (no-borrow on subtract) |
| adder_ovf | input | 1 | Adder signed overflow |
| shifter_carry | input | 1 | Shifter carry-out |
| sat_hit | input | 1 | Instruction saturated |
| wr_en | input | 1 | Direct flag write |
| wr_flags | input | 5 | Value for direct write {N,Z,C,V,Q} |
| exec_en | output | 1 | Instruction may commit |
| flags_out | output | 5 | Current flags {N,Z,C,V,Q} |

## Verification
The bench builds the unit with DATA_W = 4. At that width every result value, including the all-zero and negative ones, can be swept together with every combination of adder carry, adder overflow, shifter carry and both operation classes. Every one of the sixteen flag patterns is crossed with all sixteen condition codes, so the whole predication table is checked. Directed sequences cover saturation stickiness, discarded instructions, and a direct write colliding with a flag-setting instruction.

// File: rtl/flag_pred_pkg.sv
package flag_pred_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
        logic q;
    } flags_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    // Condition pairs: bit 0 of the code inverts the base test
    typedef enum logic [2:0] {
        CB_ZERO   = 3'd0,
        CB_CARRY  = 3'd1,
        CB_NEG    = 3'd2,
        CB_OVF    = 3'd3,
        CB_HIGHER = 3'd4,
        CB_SGE    = 3'd5,
        CB_SGT    = 3'd6,
        CB_ALWAYS = 3'd7
    } cond_base_e;

endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import flag_pred_pkg::*;
(
    input  logic [3:0] cond_code,
    input  nzcv_t      cur,
    output logic       pass
);
    cond_base_e base_sel;
    logic       base_ok;

    always_comb begin
        base_sel = cond_base_e'(cond_code[3:1]);
        unique case (base_sel)
            CB_ZERO:   base_ok = cur.z;
            CB_CARRY:  base_ok = cur.c;
            CB_NEG:    base_ok = cur.n;
            CB_OVF:    base_ok = cur.v;
            CB_HIGHER: base_ok = cur.c & ~cur.z;
            CB_SGE:    base_ok = (cur.n == cur.v);
            CB_SGT:    base_ok = ~cur.z & (cur.n == cur.v);
            CB_ALWAYS: base_ok = 1'b1;
            default:   base_ok = 1'b0;
        endcase
        // inverting the always-true pair yields the never code
        pass = base_ok ^ cond_code[0];
    end

    always_comb begin
        if (cond_code == 4'b1111) begin
            AST_NEVER_CODE: assert (!pass); // R3
        end
        if (cond_code == 4'b1110) begin
            AST_ALWAYS_CODE: assert (pass); // R3
        end
    end

endmodule

// File: rtl/flag_calc.sv
module flag_calc
    import flag_pred_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] result,
    input  logic              op_arith,
    input  logic              adder_carry,
    input  logic              adder_ovf,
    input  logic              shifter_carry,
    input  nzcv_t             cur,
    output nzcv_t             upd
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        upd.n = result[MSB];
        upd.z = (result == '0);
        if (op_arith) begin
            upd.c = adder_carry;
            upd.v = adder_ovf;
        end else begin
            upd.c = shifter_carry;
            upd.v = cur.v;
        end
    end

endmodule

// File: rtl/flag_pred_unit.sv
module flag_pred_unit
    import flag_pred_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [3:0]        cond_code,
    input  logic              set_flags,
    input  logic              op_arith,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              adder_carry,
    input  logic              adder_ovf,
    input  logic              shifter_carry,
    input  logic              sat_hit,
    input  logic              wr_en,
    input  logic [4:0]        wr_flags,
    output logic              exec_en,
    output logic [4:0]        flags_out
);
    flags_t flags_q;
    flags_t flags_d;
    nzcv_t  cur_nzcv;
    nzcv_t  calc_nzcv;
    logic   cond_ok;
    logic   commit_flags;

    assign cur_nzcv = '{n: flags_q.n, z: flags_q.z, c: flags_q.c, v: flags_q.v};

    cond_eval u_cond (
        .cond_code (cond_code),
        .cur       (cur_nzcv),
        .pass      (cond_ok)
    );

    flag_calc #(.DATA_W(DATA_W)) u_calc (
        .result        (alu_result),
        .op_arith      (op_arith),
        .adder_carry   (adder_carry),
        .adder_ovf     (adder_ovf),
        .shifter_carry (shifter_carry),
        .cur           (cur_nzcv),
        .upd           (calc_nzcv)
    );

    assign exec_en      = instr_valid & cond_ok;
    assign commit_flags = exec_en & set_flags;

    always_comb begin
        flags_d = flags_q;
        if (commit_flags) begin
            flags_d.n = calc_nzcv.n;
            flags_d.z = calc_nzcv.z;
            flags_d.c = calc_nzcv.c;
            flags_d.v = calc_nzcv.v;
        end
        if (exec_en && sat_hit) begin
            flags_d.q = 1'b1;
        end
        if (wr_en) begin
            flags_d = flags_t'(wr_flags);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_out = flags_q;

    AST_IDLE_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> !exec_en); // R2

    AST_Z_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && exec_en && set_flags) |=> (flags_out[3] == ($past(alu_result) == '0))); // R4

    AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && exec_en && set_flags && !op_arith) |=> $stable(flags_out[1])); // R6

    AST_NO_UPDATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(exec_en && set_flags)) |=> $stable(flags_out[4:1])); // R7

    AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_out[0] && !wr_en) |=> flags_out[0]); // R9

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (flags_out == $past(wr_flags))); // R10

endmodule

// File: tb/tb_flag_pred_unit.sv
module tb_flag_pred_unit;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [3:0]    cond_code = 4'b1110;
    logic          set_flags = 1'b0;
    logic          op_arith = 1'b0;
    logic [TW-1:0] alu_result = '0;
    logic          adder_carry = 1'b0;
    logic          adder_ovf = 1'b0;
    logic          shifter_carry = 1'b0;
    logic          sat_hit = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_flags = '0;
    logic          exec_en;
    logic [4:0]    flags_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flag_pred_unit #(.DATA_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .cond_code(cond_code),
        .set_flags(set_flags), .op_arith(op_arith), .alu_result(alu_result),
        .adder_carry(adder_carry), .adder_ovf(adder_ovf), .shifter_carry(shifter_carry),
        .sat_hit(sat_hit), .wr_en(wr_en), .wr_flags(wr_flags),
        .exec_en(exec_en), .flags_out(flags_out)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic model_pass(input logic [3:0] cc, input logic [3:0] f);
        logic n, z, c, v;
        n = f[3]; z = f[2]; c = f[1]; v = f[0];
        case (cc)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c && !z;
            4'd9:  return !c || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic idle_inputs();
        instr_valid = 1'b0; set_flags = 1'b0; sat_hit = 1'b0; wr_en = 1'b0;
        cond_code = 4'b1110; op_arith = 1'b0; alu_result = '0;
        adder_carry = 1'b0; adder_ovf = 1'b0; shifter_carry = 1'b0;
    endtask

    task automatic do_write(input logic [4:0] f);
        @(negedge clk);
        idle_inputs();
        wr_en = 1'b1; wr_flags = f;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_instr(input logic [3:0] cc, input logic sf, input logic ar,
                            input logic [TW-1:0] res, input logic ac, input logic av,
                            input logic sc, input logic sat, output logic ex);
        @(negedge clk);
        idle_inputs();
        instr_valid = 1'b1; cond_code = cc; set_flags = sf; op_arith = ar;
        alu_result = res; adder_carry = ac; adder_ovf = av; shifter_carry = sc; sat_hit = sat;
        #1 ex = exec_en;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        logic ex;
        logic [4:0] pre;
        logic [4:0] exp;
        idle_inputs();
        repeat (2) @(negedge clk);
        check("R1 reset flags", flags_out, 5'b00000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after release", flags_out, 5'b00000);
        check("R2 idle exec_en", {4'b0, exec_en}, 5'b0);

        // R2 / R3: full predication table
        for (int f = 0; f < 16; f++) begin
            do_write({f[3:0], 1'b0});
            for (int cc = 0; cc < 16; cc++) begin
                @(negedge clk);
                instr_valid = 1'b1; cond_code = cc[3:0];
                #1;
                check((cc >= 14) ? "R3 always/never" : "R2 condition table",
                      {4'b0, exec_en}, {4'b0, model_pass(cc[3:0], f[3:0])});
                instr_valid = 1'b0;
            end
        end

        // R4 / R5 / R6: flag update sweep
        for (int a = 0; a < 2; a++) begin
            for (int r = 0; r < 16; r++) begin
                for (int k = 0; k < 8; k++) begin
                    pre = 5'((r * 7 + k * 3 + a * 5) % 32);
                    do_write(pre);
                    do_instr(4'b1110, 1'b1, a[0], r[TW-1:0], k[0], k[1], k[2], 1'b0, ex);
                    exp[4] = r[3];
                    exp[3] = (r == 0);
                    exp[2] = a[0] ? k[0] : k[2];
                    exp[1] = a[0] ? k[1] : pre[1];
                    exp[0] = pre[0];
                    check(a[0] ? "R4 R5 arith update" : "R4 R6 logical update", flags_out, exp);
                end
            end
        end

        // R4: subtract to zero sets Z
        do_write(5'b00000);
        do_instr(4'b1110, 1'b1, 1'b1, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, ex);
        check("R4 subtract zero", flags_out, 5'b01100);

        // R7: no qualifier keeps flags
        for (int f = 0; f < 32; f++) begin
            do_write(f[4:0]);
            do_instr(4'b1110, 1'b0, f[0], 4'(~f), 1'b1, 1'b1, 1'b1, 1'b0, ex);
            check("R7 no set_flags", flags_out, f[4:0]);
        end

        // R8: discarded instruction changes nothing
        do_write(5'b10110);
        do_instr(4'b0000, 1'b1, 1'b1, 4'd0, 1'b0, 1'b1, 1'b0, 1'b1, ex);
        check("R8 discarded exec_en", {4'b0, ex}, 5'b0);
        check("R8 discarded flags", flags_out, 5'b10110);
        do_instr(4'b1111, 1'b1, 1'b0, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1, ex);
        check("R8 never-code flags", flags_out, 5'b10110);

        // R9: Q sticky
        do_write(5'b00000);
        do_instr(4'b1110, 1'b0, 1'b0, 4'd3, 1'b0, 1'b0, 1'b0, 1'b1, ex);
        check("R9 sat sets Q", flags_out, 5'b00001);
        do_instr(4'b1110, 1'b1, 1'b1, 4'd5, 1'b0, 1'b0, 1'b0, 1'b0, ex);
        check("R9 Q survives flag update", flags_out, 5'b00001);
        do_instr(4'b1110, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, ex);
        check("R9 Q survives plain instr", flags_out, 5'b00001);

        // R10: direct write clears Q and wins over an instruction
        do_write(5'b11110);
        check("R10 write clears Q", flags_out, 5'b11110);
        @(negedge clk);
        idle_inputs();
        instr_valid = 1'b1; cond_code = 4'b1110; set_flags = 1'b1; op_arith = 1'b1;
        alu_result = 4'd0; adder_carry = 1'b0; adder_ovf = 1'b0; sat_hit = 1'b1;
        wr_en = 1'b1; wr_flags = 5'b00010;
        @(negedge clk);
        idle_inputs();
        check("R10 write priority", flags_out, 5'b00010);

        // R1: reset after activity
        rst_n = 1'b0;
        #1 check("R1 reset re-asserted", flags_out, 5'b00000);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule